// File: doc/BRIEF.md
# Multi-Source Reset Arbiter

This block turns three reset sources into classified reset outputs for a small processor core. The sources are an active-low external power-on pin, a watchdog overflow event and an active-low external manual reset pin. A pin power-on reset asserts the power-on class output asynchronously and releases it through a two-stage synchroniser. A watchdog overflow, when the watchdog is set up to generate resets, produces a stretched power-on class reset. A manual reset produces only the manual class output.

The manual pin is synchronised and must be seen low for a minimum number of clock cycles before the request counts. Entry into manual reset waits until any bus cycle in progress has ended. The manual reset state is held until the pin returns high. A separate domain reset, driven only by the power-on pin, serves the clock-control and watchdog registers. A watchdog overflow flag and a reset-cause code record the last reset. The watchdog counter, the clock generator and the bus master are outside the block; only their signals are seen.

Top module: `rst_arbiter`

## Requirements
- R1: Driving `por_pin_n` low asserts `por_class` high and `dom_rst_n` low at once, without waiting for a clock edge. After the pin returns high, both outputs release on the second rising clock edge.
- R2: If `wdt_ovf` and `wdt_rst_en` are both high at a rising edge, `por_class` is high for exactly `WDT_HOLD` (default 4) cycles starting at that edge. With `wdt_rst_en` low, `wdt_ovf` has no effect on any output.
- R3: A watchdog-caused reset never drives `dom_rst_n` low.
- R4: When the power-on pin and a watchdog overflow occur together, the pin reset wins: `wdt_flag` is 0 and `cause` is 2'b01. Overflows are ignored until the power-on release has finished.
- R5: A manual request is accepted only after the synchronised `mrst_pin_n` has been sampled low on `MIN_LOW` (default 20) consecutive edges. Shorter low pulses leave every output unchanged. With the bus idle, `mrst_class` rises on the 23rd edge after the pin falls.
- R6: While `bus_busy` is high, an accepted manual request waits. `mrst_class` rises on the first edge at which `bus_busy` is low, and never at an edge where `bus_busy` was high.
- R7: `mrst_class` stays high while the pin is low. It falls on the third edge after the pin returns high, at which point the manual exception processing starts.
- R8: While `mrst_class` is high, `por_class` stays low and `dom_rst_n` stays high.
- R9: `cause` reads 2'b01 after a pin power-on reset, 2'b10 after a watchdog reset and 2'b11 after a manual reset, and holds that value until the next reset.
- R10: `wdt_flag` is set by a watchdog reset and is kept through manual and further watchdog resets. A high `flag_clr` at an edge clears it (a same-edge watchdog reset wins), and so does a pin power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_pin_n | input | 1 | External power-on reset pin, active low, asynchronous |
| mrst_pin_n | input | 1 | External manual reset pin, active low, asynchronous |
| wdt_ovf | input | 1 | Watchdog counter overflow event |
| wdt_rst_en | input | 1 | Watchdog set up to generate resets |
| bus_busy | input | 1 | A bus cycle is in progress |
| flag_clr | input | 1 | Software write clearing the overflow flag |
| por_class | output | 1 | Power-on class reset request, active high |
| mrst_class | output | 1 | Manual class reset request (CPU state only), active high |
| dom_rst_n | output | 1 | Clock-control and watchdog register domain reset, active low |
| wdt_flag | output | 1 | Watchdog overflow flag |
| cause | output | 2 | Cause of the last reset |

## Verification
Some properties are checked on every cycle. The assertions confirm that the manual class never coincides with a power-on class reset or a domain reset, and that a watchdog reset leaves the domain reset inactive. They also confirm that manual entry follows an idle bus and a full qualification count, that a qualified watchdog event starts a full hold and sets the flag, and that the cause code is never zero. Other behaviour needs the bench scenarios. These cover the exact pulse-length boundary of 19 against 20 low cycles, the asynchronous assertion and two-edge release of the pin reset, priority when the pin and the watchdog act together, and the flag surviving a manual reset.

// File: rtl/rsa_pkg.sv
package rsa_pkg;
  typedef enum logic [1:0] {
    M_IDLE = 2'd0,
    M_QUAL = 2'd1,
    M_HELD = 2'd2
  } mstate_e;

  localparam logic [1:0] CAUSE_PIN  = 2'b01;
  localparam logic [1:0] CAUSE_WDOG = 2'b10;
  localparam logic [1:0] CAUSE_MAN  = 2'b11;
endpackage

// File: rtl/rsa_sync.sv
module rsa_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/rsa_manual.sv
module rsa_manual
  import rsa_pkg::*;
#(
  parameter int MIN_LOW = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_lvl,
  input  logic bus_busy,
  input  logic hold_idle,
  output logic enter,
  output logic active
);
  localparam int CNT_W = (MIN_LOW > 2) ? $clog2(MIN_LOW) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_LOW - 1);

  mstate_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    enter = 1'b0;
    if (hold_idle) begin
      st_d  = M_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        M_IDLE: begin
          if (!pin_lvl) begin
            if (cnt_q == LAST) st_d = M_QUAL;
            else               cnt_d = cnt_q + CNT_W'(1);
          end else begin
            cnt_d = '0;
          end
        end
        M_QUAL: begin
          if (!bus_busy) begin
            st_d  = M_HELD;
            enter = 1'b1;
          end
        end
        M_HELD: begin
          if (pin_lvl) begin
            st_d  = M_IDLE;
            cnt_d = '0;
          end
        end
        default: begin
          st_d  = M_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= M_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign active = (st_q == M_HELD);

  // R5
  full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> ($past(cnt_q) == LAST));

  // R6
  bus_idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !$past(bus_busy));

  // R7
  pin_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && pin_lvl && !hold_idle) |=> !active);
endmodule

// File: rtl/rsa_wdog.sv
module rsa_wdog #(
  parameter int WDT_HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic flag_clr,
  output logic active,
  output logic flag
);
  localparam int HW = $clog2(WDT_HOLD + 1);
  localparam logic [HW-1:0] HOLD_LD = HW'(WDT_HOLD);

  logic [HW-1:0] cnt_q, cnt_d;
  logic flag_q, flag_d;

  always_comb begin
    cnt_d = cnt_q;
    if (fire)              cnt_d = HOLD_LD;
    else if (cnt_q != '0)  cnt_d = cnt_q - HW'(1);

    flag_d = flag_q;
    if (fire)          flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign active = (cnt_q != '0);
  assign flag   = flag_q;

  // R2
  hold_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (active && cnt_q == HOLD_LD));

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> flag);

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !fire) |=> !flag);
endmodule

// File: rtl/rst_arbiter.sv
module rst_arbiter
  import rsa_pkg::*;
#(
  parameter int MIN_LOW  = 20,
  parameter int WDT_HOLD = 4
) (
  input  logic       clk,
  input  logic       por_pin_n,
  input  logic       mrst_pin_n,
  input  logic       wdt_ovf,
  input  logic       wdt_rst_en,
  input  logic       bus_busy,
  input  logic       flag_clr,
  output logic       por_class,
  output logic       mrst_class,
  output logic       dom_rst_n,
  output logic       wdt_flag,
  output logic [1:0] cause
);
  logic por_rel, man_lvl;
  logic wd_fire, wd_active;
  logic man_enter, man_active;
  logic [1:0] cause_q, cause_d;

  rsa_sync #(.RST_VAL(1'b0)) u_por_sync (
    .clk(clk), .rst_n(por_pin_n), .d(1'b1), .q(por_rel)
  );

  rsa_sync #(.RST_VAL(1'b1)) u_man_sync (
    .clk(clk), .rst_n(por_pin_n), .d(mrst_pin_n), .q(man_lvl)
  );

  assign wd_fire = wdt_ovf && wdt_rst_en && por_rel;

  rsa_wdog #(.WDT_HOLD(WDT_HOLD)) u_wdog (
    .clk(clk), .rst_n(por_pin_n), .fire(wd_fire), .flag_clr(flag_clr),
    .active(wd_active), .flag(wdt_flag)
  );

  rsa_manual #(.MIN_LOW(MIN_LOW)) u_manual (
    .clk(clk), .rst_n(por_pin_n), .pin_lvl(man_lvl), .bus_busy(bus_busy),
    .hold_idle(wd_fire || wd_active || !por_rel),
    .enter(man_enter), .active(man_active)
  );

  always_comb begin
    cause_d = cause_q;
    if (wd_fire)        cause_d = CAUSE_WDOG;
    else if (man_enter) cause_d = CAUSE_MAN;
  end

  always_ff @(posedge clk or negedge por_pin_n) begin
    if (!por_pin_n) cause_q <= CAUSE_PIN;
    else            cause_q <= cause_d;
  end

  assign por_class  = !por_rel || wd_active;
  assign mrst_class = man_active;
  assign dom_rst_n  = por_rel;
  assign cause      = cause_q;

  // R8
  manual_only_chk: assert property (@(posedge clk) disable iff (!por_pin_n)
    mrst_class |-> (!por_class && dom_rst_n));

  // R3
  domain_untouched_chk: assert property (@(posedge clk) disable iff (!por_pin_n)
    wd_active |-> dom_rst_n);

  // R9
  cause_valid_chk: assert property (@(posedge clk) disable iff (!por_pin_n)
    cause != 2'b00);
endmodule

// File: tb/sim_rst_arbiter.sv
`timescale 1ns/1ps
module sim_rst_arbiter;
  logic clk = 1'b0;
  logic por_pin_n, mrst_pin_n, wdt_ovf, wdt_rst_en, bus_busy, flag_clr;
  logic por_class, mrst_class, dom_rst_n, wdt_flag;
  logic [1:0] cause;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  int saw_cnt = 0;
  int bad_cnt = 0;
  logic mq = 1'b0;
  logic bq = 1'b0;

  always #2.5 clk = ~clk;

  rst_arbiter u0 (
    .clk(clk), .por_pin_n(por_pin_n), .mrst_pin_n(mrst_pin_n),
    .wdt_ovf(wdt_ovf), .wdt_rst_en(wdt_rst_en), .bus_busy(bus_busy),
    .flag_clr(flag_clr), .por_class(por_class), .mrst_class(mrst_class),
    .dom_rst_n(dom_rst_n), .wdt_flag(wdt_flag), .cause(cause)
  );

  // Counts cycles with the manual class active and entries made while the bus was busy
  always @(posedge clk) begin
    if (mrst_class) saw_cnt <= saw_cnt + 1;
    if (mrst_class && !mq && bq) bad_cnt <= bad_cnt + 1;
    mq <= mrst_class;
    bq <= bus_busy;
  end

  // {low length[7:0], bus busy, expect manual reset}
  localparam logic [9:0] VEC [8] = '{
    {8'd5,  1'b0, 1'b0},
    {8'd19, 1'b0, 1'b0},
    {8'd20, 1'b0, 1'b1},
    {8'd21, 1'b0, 1'b1},
    {8'd40, 1'b0, 1'b1},
    {8'd19, 1'b1, 1'b0},
    {8'd30, 1'b1, 1'b1},
    {8'd60, 1'b1, 1'b1}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog timeout (all requirements) actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    por_pin_n = 1'b0; mrst_pin_n = 1'b1; wdt_ovf = 1'b0; wdt_rst_en = 1'b1;
    bus_busy = 1'b0; flag_clr = 1'b0;
    tick(3);
    // R1 reset state, R9 cause after pin power-on
    check("R1 por_class in reset", por_class, 1);
    check("R1 dom_rst_n in reset", dom_rst_n, 0);
    check("R8 mrst_class in reset", mrst_class, 0);
    check("R10 flag in reset", wdt_flag, 0);
    check("R9 cause pin", cause, 1);
    por_pin_n = 1'b1;
    tick(1);
    check("R1 por_class one edge after release", por_class, 1);
    tick(1);
    check("R1 por_class two edges after release", por_class, 0);
    check("R1 dom_rst_n two edges after release", dom_rst_n, 1);
    tick(2);

    // Vector table: manual pulse length and bus activity (R5, R6, R7)
    for (int i = 0; i < 8; i++) begin
      int s0, b0;
      s0 = saw_cnt; b0 = bad_cnt;
      bus_busy = VEC[i][1];
      mrst_pin_n = 1'b0;
      tick(int'(VEC[i][9:2]));
      mrst_pin_n = 1'b1;
      tick(10);
      bus_busy = 1'b0;
      tick(10);
      check($sformatf("R5 vector %0d manual seen", i), int'(saw_cnt != s0), int'(VEC[i][0]));
      check($sformatf("R6 vector %0d entry during busy", i), bad_cnt - b0, 0);
      check($sformatf("R7 vector %0d released", i), mrst_class, 0);
      if (VEC[i][0]) check($sformatf("R9 vector %0d cause manual", i), cause, 3);
    end

    // R5 exact acceptance edge, R7 exact release edge, R8 only CPU class
    mrst_pin_n = 1'b0;
    tick(22);
    check("R5 not yet accepted at edge 22", mrst_class, 0);
    tick(1);
    check("R5 accepted at edge 23", mrst_class, 1);
    check("R8 por_class during manual", por_class, 0);
    check("R8 dom_rst_n during manual", dom_rst_n, 1);
    tick(5);
    mrst_pin_n = 1'b1;
    tick(2);
    check("R7 held two edges after pin high", mrst_class, 1);
    tick(1);
    check("R7 released third edge after pin high", mrst_class, 0);
    tick(3);

    // R6 exact deferral
    bus_busy = 1'b1;
    mrst_pin_n = 1'b0;
    tick(30);
    check("R6 deferred while bus busy", mrst_class, 0);
    bus_busy = 1'b0;
    tick(1);
    check("R6 entered after bus idle", mrst_class, 1);
    mrst_pin_n = 1'b1;
    tick(5);

    // R2 / R3 / R9 / R10 watchdog reset
    wdt_ovf = 1'b1;
    tick(1);
    wdt_ovf = 1'b0;
    check("R2 por_class after overflow", por_class, 1);
    check("R3 dom_rst_n during watchdog reset", dom_rst_n, 1);
    check("R10 flag set", wdt_flag, 1);
    check("R9 cause watchdog", cause, 2);
    tick(3);
    check("R2 por_class at hold end", por_class, 1);
    tick(1);
    check("R2 por_class after hold", por_class, 0);

    // R2 overflow ignored when not enabled
    wdt_rst_en = 1'b0;
    wdt_ovf = 1'b1;
    tick(1);
    wdt_ovf = 1'b0;
    check("R2 disabled overflow por_class", por_class, 0);
    tick(2);
    check("R2 disabled overflow por_class later", por_class, 0);
    wdt_rst_en = 1'b1;

    // R10 flag survives manual reset
    mrst_pin_n = 1'b0;
    tick(25);
    mrst_pin_n = 1'b1;
    tick(5);
    check("R9 cause manual", cause, 3);
    check("R10 flag kept through manual", wdt_flag, 1);

    // R10 software clear
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
    check("R10 flag cleared by write", wdt_flag, 0);
    check("R9 cause held after clear", cause, 3);

    // R4 simultaneous pin and watchdog, with R1 asynchronous assertion
    wdt_ovf = 1'b1;
    tick(1);
    wdt_ovf = 1'b0;
    tick(6);
    check("R10 flag set again", wdt_flag, 1);
    wdt_ovf = 1'b1;
    por_pin_n = 1'b0;
    #1;
    check("R1 por_class asserted before edge", por_class, 1);
    check("R1 dom_rst_n asserted before edge", dom_rst_n, 0);
    tick(1);
    check("R4 flag cleared by pin reset", wdt_flag, 0);
    check("R4 cause pin wins", cause, 1);
    por_pin_n = 1'b1;
    tick(1);
    wdt_ovf = 1'b0;
    tick(3);
    check("R4 flag stays clear", wdt_flag, 0);
    check("R4 cause stays pin", cause, 1);
    check("R4 por_class released", por_class, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule